// File: doc/BRIEF.md
# On-Screen Display Serial Command Receiver

This block sits between a host controller's SPI master and the character/control RAM of an on-screen display engine. It listens on a three-wire SPI slave link (active-low select, clock, data in), assembles bytes, and decodes each byte by its top bits and by its position in the packet stream. The result is a sequence of single-cycle write strobes, each carrying a row, a column and an 8-bit value, in the system clock domain. The RAM has 11 rows by 32 columns. Rows 0 to 9 hold 24 character cells and two row-control bytes at columns 30 and 31. Row 10 holds window and frame control in columns 0 to 12.

Three packet styles can be used within one select-low frame. The first repeats row, column and value for every write. The second sends a row once and then column/value pairs. The third sends one row and one column and then streams values into consecutive locations. A frame may move from the first style to the second or third, and from the second back to the first. Once streaming starts, every following byte is a value until the select line rises. The SPI pins are brought into the system clock domain through multi-stage synchronizers, so the SPI clock must be several times slower than the system clock.

Top module: `osd_cmd_rx`

## Requirements
- R1: Bits are taken from mosi on rising edges of sck, MSB first, eight per byte, only while ss_n is low; sck edges while ss_n is high produce no bytes and no writes.
- R2: In a new frame, the first byte with bit 7 = 1 sets the row to bits 3:0; bytes with bit 7 = 0 that arrive before any row byte are ignored.
- R3: After a row, a byte with bit 7 = 0 and bit 6 = 0 sets the column to bits 4:0, and the next byte, whatever its value (bit 7 included), is written once to that row and column.
- R4: After a single write, a byte with bit 7 = 1 sets a new row and expects a column, and a byte with bit 7 = 0 sets a new column in the same row.
- R5: A column byte with bit 7 = 0 and bit 6 = 1 starts streaming: every later byte is written, starting at that column, and the column then advances by one; columns 24 to 29 are written like any other.
- R6: While streaming, the column wraps from 31 to 0 and the row increases by one; after column 31 of row 10 no further writes occur in that frame.
- R7: Streaming is sticky: bytes whose bit 7 or bit 6 is set are still written as values until ss_n goes high.
- R8: ss_n high ends the frame: a partly received byte is dropped and the next frame again waits for a row byte.
- R9: Every write strobe lasts exactly one clock, each complete byte yields at most one write, and no write ever names a row of 11 or above.
- R10: During and right after reset wr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | SPI slave select, active low, asynchronous to clk |
| sck | input | 1 | SPI clock, asynchronous to clk |
| mosi | input | 1 | SPI data into the block |
| wr_en | output | 1 | One-cycle RAM write strobe |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_data | output | 8 | Value to write |

## Verification
The bench builds the block with its default values of 11 rows, 32 columns and two synchronizer stages. The full-size geometry lets a stream cross the 31-to-0 column wrap into row 10 and then reach the end of row 10, where writes must stop. The default 4-bit row field also allows row addresses 11 to 15, so writes to those rows can be shown to be dropped. With an SPI half-period of eight system clocks, every byte boundary and every frame end goes through the real synchronizer latency.

// File: rtl/osd_rx_pkg.sv
// Shared definitions for the OSD serial command receiver.
// Assumes 8-bit bytes; bit positions below are part of the command encoding.
package osd_rx_pkg;
    localparam int BYTE_W   = 8;
    localparam int ROW_FLAG = 7;   // set in a row address byte
    localparam int AUTO_BIT = 6;   // set in a column byte to start streaming

    typedef enum logic [1:0] {
        ST_WAIT_ROW = 2'd0,   // frame start: only a row byte is accepted
        ST_ADDR     = 2'd1,   // expecting a row or a column byte
        ST_VALUE    = 2'd2,   // next byte is a single value
        ST_STREAM   = 2'd3    // every byte is a value, address auto-advances
    } dec_state_t;
endpackage

// File: rtl/osd_rx_sync.sv
// Multi-stage synchronizer for a small vector of asynchronous inputs.
// Assumes each bit is independent; every stage resets to RST_VAL.
module osd_rx_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_async;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage resolves metastability of the one before.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/osd_rx_shifter.sv
// Assembles synchronized SPI bits into bytes.
// Assumes sck, mosi and ss_n come through equal synchronizer depth and that
// sck stays at each level for at least two system clocks.
module osd_rx_shifter
    import osd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              ss_s,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sck_d;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sck_rise;
    logic [BYTE_W-1:0] shreg_nx;

    assign sck_rise = sck_s & ~sck_d;
    assign shreg_nx = {shreg[BYTE_W-2:0], mosi_s};

    // Delayed copy of the synchronized clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Shift on each rising edge while selected; emit a byte after the eighth bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (ss_s) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= shreg_nx;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_valid <= 1'b1;
                    byte_data  <= shreg_nx;
                end
            end
        end
    end

    // R8: a deselected link leaves no partial bit count behind.
    a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> (bit_cnt == '0));

    // R1: no byte is produced from a deselected link.
    a_r1_no_byte_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && sck_rise) |=> !byte_valid);
endmodule

// File: rtl/osd_rx_decoder.sv
// Turns received bytes into RAM writes according to the packet style.
// Assumes byte_valid pulses are separated by many clocks and that frame_idle
// is high whenever the link is deselected.
module osd_rx_decoder
    import osd_rx_pkg::*;
#(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 5,
    parameter int NUM_ROWS = 11,
    parameter int NUM_COLS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_idle,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              wr_en,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    dec_state_t       state;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             past_end;
    logic             row_ok;

    assign row_ok = (row_q <= ROW_LAST);

    // Packet state machine, address registers and registered write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT_ROW;
            row_q    <= '0;
            col_q    <= '0;
            past_end <= 1'b0;
            wr_en    <= 1'b0;
            wr_row   <= '0;
            wr_col   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (frame_idle) begin
                state    <= ST_WAIT_ROW;
                past_end <= 1'b0;
            end else if (byte_valid) begin
                unique case (state)
                    ST_WAIT_ROW: begin
                        if (byte_data[ROW_FLAG]) begin
                            row_q <= byte_data[ROW_W-1:0];
                            state <= ST_ADDR;
                        end
                    end
                    ST_ADDR: begin
                        if (byte_data[ROW_FLAG]) begin
                            row_q <= byte_data[ROW_W-1:0];
                        end else begin
                            col_q <= byte_data[COL_W-1:0];
                            state <= byte_data[AUTO_BIT] ? ST_STREAM : ST_VALUE;
                        end
                    end
                    ST_VALUE: begin
                        wr_en   <= row_ok;
                        wr_row  <= row_q;
                        wr_col  <= col_q;
                        wr_data <= byte_data;
                        state   <= ST_ADDR;
                    end
                    ST_STREAM: begin
                        wr_en   <= row_ok && !past_end;
                        wr_row  <= row_q;
                        wr_col  <= col_q;
                        wr_data <= byte_data;
                        if (col_q == COL_LAST) begin
                            col_q <= '0;
                            if (row_q >= ROW_LAST) past_end <= 1'b1;
                            else                   row_q    <= row_q + 1'b1;
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                    default: state <= ST_WAIT_ROW;
                endcase
            end
        end
    end

    // R7: streaming is left only through the end of the frame.
    a_r7_stream_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !frame_idle) |=> (state == ST_STREAM));

    // R8: a frame end always returns to waiting for a row.
    a_r8_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idle |=> (state == ST_WAIT_ROW));

    // R2: no write can come out before a row has been received.
    a_r2_row_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_ROW) |=> !wr_en);
endmodule

// File: rtl/osd_cmd_rx.sv
// Top of the OSD serial command receiver: synchronizers, byte assembly and
// packet decoding. Assumes sck is at least four times slower than clk.
module osd_cmd_rx
    import osd_rx_pkg::*;
#(
    parameter int ROW_W       = 4,
    parameter int COL_W       = 5,
    parameter int NUM_ROWS    = 11,
    parameter int NUM_COLS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ss_n,
    input  logic             sck,
    input  logic             mosi,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data
);
    logic [2:0]        pins_s;
    logic              byte_valid;
    logic [BYTE_W-1:0] byte_data;

    osd_rx_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ss_n, sck, mosi}),
        .q_sync  (pins_s)
    );

    osd_rx_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s[1]),
        .mosi_s     (pins_s[0]),
        .ss_s       (pins_s[2]),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    osd_rx_decoder #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_idle (pins_s[2]),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .wr_en      (wr_en),
        .wr_row     (wr_row),
        .wr_col     (wr_col),
        .wr_data    (wr_data)
    );

    // R9: a write strobe never lasts more than one clock.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R9: writes only ever name rows present in the RAM.
    a_r9_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row < ROW_W'(NUM_ROWS)));

    // R9: each write follows a completed byte by exactly one clock.
    a_r9_write_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_valid));
endmodule

// File: tb/osd_cmd_rx_tb.sv
module osd_cmd_rx_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ss_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       wr_en;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;

    int         log_n = 0;
    logic [3:0] log_row [64];
    logic [4:0] log_col [64];
    logic [7:0] log_dat [64];
    int         exp_n = 0;
    logic [3:0] exp_row [64];
    logic [4:0] exp_col [64];
    logic [7:0] exp_dat [64];
    int         long_pulse = 0;
    logic       wr_en_prev = 1'b0;

    always #2 clk = ~clk;

    osd_cmd_rx dut_i (
        .clk (clk), .rst_n (rst_n), .ss_n (ss_n), .sck (sck), .mosi (mosi),
        .wr_en (wr_en), .wr_row (wr_row), .wr_col (wr_col), .wr_data (wr_data)
    );

    // Record every write seen at the port, and any strobe longer than a clock.
    always @(negedge clk) begin
        if (wr_en && log_n < 64) begin
            log_row[log_n] = wr_row;
            log_col[log_n] = wr_col;
            log_dat[log_n] = wr_data;
            log_n++;
        end
        if (wr_en && wr_en_prev) long_pulse++;
        wr_en_prev = wr_en;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_w(input logic [3:0] r, input logic [4:0] c, input logic [7:0] d);
        exp_row[exp_n] = r; exp_col[exp_n] = c; exp_dat[exp_n] = d; exp_n++;
    endtask

    task automatic clear_logs();
        log_n = 0; exp_n = 0;
    endtask

    task automatic verify(input string req);
        check({req, " write count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check({req, " row"}, int'(log_row[i]), int'(exp_row[i]));
            check({req, " col"}, int'(log_col[i]), int'(exp_col[i]));
            check({req, " data"}, int'(log_dat[i]), int'(exp_dat[i]));
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = b[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic frame_begin();
        ss_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (HALF) @(negedge clk);
        ss_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_logs();
        repeat (5) @(negedge clk);
        check("R10 wr_en in reset", int'(wr_en), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R10 wr_en after reset", int'(wr_en), 0);
        verify("R10");
    endtask

    task automatic t_per_write();   // R2 R3 R4: full address each time
        clear_logs();
        frame_begin();
        send_byte(8'h83); send_byte(8'h05); send_byte(8'hA7);
        send_byte(8'h81); send_byte(8'h1E); send_byte(8'h3C);
        frame_end();
        expect_w(4'd3, 5'd5, 8'hA7);
        expect_w(4'd1, 5'd30, 8'h3C);
        verify("R3 R4 per-write");
    endtask

    task automatic t_pairs();       // R4: row once, then column/value pairs
        clear_logs();
        frame_begin();
        send_byte(8'h82); send_byte(8'h00); send_byte(8'h11);
        send_byte(8'h17); send_byte(8'hF2);
        send_byte(8'h1F); send_byte(8'h55);
        send_byte(8'h84); send_byte(8'h09); send_byte(8'hC3);
        frame_end();
        expect_w(4'd2, 5'd0, 8'h11);
        expect_w(4'd2, 5'd23, 8'hF2);
        expect_w(4'd2, 5'd31, 8'h55);
        expect_w(4'd4, 5'd9, 8'hC3);
        verify("R4 pairs");
    endtask

    task automatic t_no_row();      // R2: column-like bytes before a row are ignored
        clear_logs();
        frame_begin();
        send_byte(8'h05); send_byte(8'h44);
        send_byte(8'h84); send_byte(8'h02); send_byte(8'h99);
        frame_end();
        expect_w(4'd4, 5'd2, 8'h99);
        verify("R2 no row");
    endtask

    task automatic t_stream_wrap(); // R5 R6 R7: wrap into row 10, sticky values
        clear_logs();
        frame_begin();
        send_byte(8'h89); send_byte(8'h5C);
        send_byte(8'h83); send_byte(8'h41); send_byte(8'hC0);
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        frame_end();
        expect_w(4'd9, 5'd28, 8'h83);
        expect_w(4'd9, 5'd29, 8'h41);
        expect_w(4'd9, 5'd30, 8'hC0);
        expect_w(4'd9, 5'd31, 8'h12);
        expect_w(4'd10, 5'd0, 8'h34);
        expect_w(4'd10, 5'd1, 8'h56);
        verify("R5 R6 R7 stream");
    endtask

    task automatic t_stream_gap();  // R5: columns 24..29 written in sequence
        clear_logs();
        frame_begin();
        send_byte(8'h80); send_byte(8'h57);
        for (int i = 0; i < 8; i++) send_byte(8'(8'h20 + i));
        frame_end();
        for (int i = 0; i < 8; i++) expect_w(4'd0, 5'(23 + i), 8'(8'h20 + i));
        verify("R5 gap columns");
    endtask

    task automatic t_stream_end();  // R6 R8: stop after row 10, next frame restarts
        clear_logs();
        frame_begin();
        send_byte(8'h8A); send_byte(8'h5E);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
        frame_end();
        frame_begin();
        send_byte(8'h80); send_byte(8'h00); send_byte(8'h77);
        frame_end();
        expect_w(4'd10, 5'd30, 8'h01);
        expect_w(4'd10, 5'd31, 8'h02);
        expect_w(4'd0, 5'd0, 8'h77);
        verify("R6 R8 end of RAM");
    endtask

    task automatic t_partial();     // R8: partial byte dropped, frame restarts
        clear_logs();
        frame_begin();
        send_byte(8'h81); send_byte(8'h03);
        send_bits(8'hF0, 4);
        frame_end();
        frame_begin();
        send_byte(8'h44);
        send_byte(8'h85); send_byte(8'h06); send_byte(8'h66);
        frame_end();
        expect_w(4'd5, 5'd6, 8'h66);
        verify("R8 partial");
    endtask

    task automatic t_deselected();  // R1: clocks with ss_n high are ignored
        clear_logs();
        send_byte(8'h83); send_byte(8'h01); send_byte(8'hEE);
        repeat (20) @(negedge clk);
        check("R1 writes while deselected", log_n, 0);
        frame_begin();
        send_byte(8'h86); send_byte(8'h04); send_byte(8'h5A);
        frame_end();
        expect_w(4'd6, 5'd4, 8'h5A);
        verify("R1 after deselected");
    endtask

    task automatic t_bad_row();     // R9: rows 11..15 never written
        clear_logs();
        frame_begin();
        send_byte(8'h8B); send_byte(8'h01); send_byte(8'h12);
        send_byte(8'h8F); send_byte(8'h40); send_byte(8'h13);
        frame_end();
        verify("R9 bad row");
        check("R9 strobe width", long_pulse, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_per_write();
        t_pairs();
        t_no_row();
        t_stream_wrap();
        t_stream_gap();
        t_stream_end();
        t_partial();
        t_deselected();
        t_bad_row();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule